// File: doc/BRIEF.md
# Column Driver Line Capture Front End

This block is the digital front end of a cascadable LCD column driver. Each shift clock it takes two pixel ports, each carrying red, green and blue 8-bit gray codes, so six codes arrive per clock. Either port can be bitwise inverted by its own control input. A group pointer walks the 384 output slots in either direction. It writes the six codes into a first storage bank, so a full line takes 64 clocks.

A line-load strobe copies the whole first bank into a second bank in one step. The second bank drives the gray-code outputs that feed the decoders, and it comes with a per-output polarity flag for dot inversion. Chips are chained through a pair of start-pulse pins. The pin on the starting side is the input, and the chip pulses the far pin during its last capture clock, so the next chip in the chain continues without a gap.

Top module: `coldrv_capture`

## Requirements
- R1: While reset is asserted and after it is released, both banks hold zero, the pointer is idle, both start-pulse outputs are low and the polarity base is 0.
- R2: With `dir_rev` low, the capture of group g (0..63, counted from the first clock after the start pulse) writes slots 6g+k for k = 0..5. Lane k = 0,1,2 is `port_a` bits [23:16], [15:8], [7:0], and lanes 3,4,5 are the same fields of `port_b`. Slot s appears at `gray_codes[8s+7:8s]`.
- R3: With `dir_rev` high, group g writes lane k into slot 383-6g-k.
- R4: When `inv_a` (or `inv_b`) is high in a capture clock, that port's three codes are stored bitwise inverted. When it is low, they are stored unchanged.
- R5: In the idle state, a high start input on the starting side begins capture on the next clock. The starting side is `start_lo_i` for forward and `start_hi_i` for reverse. The direction is taken at that same clock, and the start input on the other side is ignored.
- R6: The far-side start output is high for exactly the one clock in which group 63 is presented: `start_hi_o` going forward, `start_lo_o` in reverse. The near-side output stays low. The output enables are `start_lo_oe` = `dir_rev` and `start_hi_oe` = not `dir_rev`.
- R7: After group 63 the pointer is idle, and clocks without a start pulse leave the first bank unchanged.
- R8: On `line_ld` all 384 codes of the first bank move into the second bank in one clock. Without `line_ld` the second bank holds.
- R9: When `line_ld` coincides with a capture clock, the second bank receives the first-bank contents from before that clock's write, and the write still lands in the first bank.
- R10: `dot_pol[s]` equals the frame bit XOR bit 0 of s, where the frame bit is `frame_alt` sampled on `line_ld`.
- R11: A start pulse received while a line is being captured is ignored, and the line completes at its original group count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_rev | input | 1 | 0: slots 0 to 383, 1: slots 383 to 0 |
| start_lo_i | input | 1 | Start input from low-side pin |
| start_hi_i | input | 1 | Start input from high-side pin |
| start_lo_o | output | 1 | Cascade pulse to low-side pin |
| start_hi_o | output | 1 | Cascade pulse to high-side pin |
| start_lo_oe | output | 1 | Low-side pin drive enable |
| start_hi_oe | output | 1 | High-side pin drive enable |
| port_a | input | 24 | Port A codes R/G/B |
| port_b | input | 24 | Port B codes R/G/B |
| inv_a | input | 1 | Invert port A codes |
| inv_b | input | 1 | Invert port B codes |
| line_ld | input | 1 | Line-load strobe |
| frame_alt | input | 1 | Polarity alternation, sampled on line_ld |
| gray_codes | output | 3072 | Second-bank codes, slot s at [8s+7:8s] |
| dot_pol | output | 384 | Per-slot polarity flag |

## Verification
The line-load copy and a capture write can land on the same clock. The bench provokes this by raising `line_ld` in the middle of a reverse line, at group 20. The scoreboard expects the second bank to show groups 0..19 of the new line and the previous line everywhere else. A later plain load must then show the complete new line, including the group written in the shared clock.

// File: rtl/coldrv_pkg.sv
package coldrv_pkg;
  localparam int unsigned NUM_PORTS   = 2;
  localparam int unsigned CH_PER_PORT = 3;
  localparam int unsigned LANES       = NUM_PORTS * CH_PER_PORT;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_LOAD = 1'b1
  } cap_state_e;
endpackage

// File: rtl/coldrv_invert.sv
module coldrv_invert #(
  parameter int unsigned CODE_W = 8,
  parameter int unsigned CH     = 3
) (
  input  logic [CH*CODE_W-1:0] data_i,
  input  logic                 inv_i,
  output logic [CH*CODE_W-1:0] data_o
);
  always_comb begin
    data_o = data_i ^ {(CH*CODE_W){inv_i}};
  end
endmodule

// File: rtl/coldrv_addr.sv
module coldrv_addr
  import coldrv_pkg::*;
#(
  parameter int unsigned NUM_OUT = 384,
  parameter int unsigned LN      = 6,
  localparam int unsigned GROUPS = NUM_OUT / LN,
  localparam int unsigned GW     = $clog2(GROUPS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dir_rev,
  input  logic          start_lo_i,
  input  logic          start_hi_i,
  output logic          wr_en,
  output logic [GW-1:0] grp,
  output logic          dir_q,
  output logic          casc_lo_o,
  output logic          casc_hi_o
);
  localparam logic [GW-1:0] LAST = GW'(GROUPS - 1);

  cap_state_e    state_q, state_d;
  logic [GW-1:0] grp_q, grp_d;
  logic          dir_d;
  logic          start_sel;
  logic          at_last;

  always_comb begin
    start_sel = dir_rev ? start_hi_i : start_lo_i;
    at_last   = (state_q == ST_LOAD) && (grp_q == LAST);
    state_d   = state_q;
    grp_d     = grp_q;
    dir_d     = dir_q;
    case (state_q)
      ST_IDLE: begin
        if (start_sel) begin
          state_d = ST_LOAD;
          grp_d   = '0;
          dir_d   = dir_rev;
        end
      end
      ST_LOAD: begin
        if (grp_q == LAST) begin
          state_d = ST_IDLE;
          grp_d   = '0;
        end else begin
          grp_d = grp_q + GW'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      grp_q   <= '0;
      dir_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      grp_q   <= grp_d;
      dir_q   <= dir_d;
    end
  end

  assign wr_en     = (state_q == ST_LOAD);
  assign grp       = grp_q;
  assign casc_lo_o = at_last && dir_q;
  assign casc_hi_o = at_last && !dir_q;

  a_r5_begin: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && start_sel) |=>
      (state_q == ST_LOAD && grp_q == '0 && dir_q == $past(dir_rev)));

  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOAD && grp_q != LAST) |=>
      (state_q == ST_LOAD && grp_q == $past(grp_q) + GW'(1)));

  a_r7_end_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOAD && grp_q == LAST) |=> (state_q == ST_IDLE));

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (casc_lo_o || casc_hi_o) |=> !(casc_lo_o || casc_hi_o));
endmodule

// File: rtl/coldrv_bank1.sv
module coldrv_bank1 #(
  parameter int unsigned NUM_OUT = 384,
  parameter int unsigned CODE_W  = 8,
  parameter int unsigned LN      = 6,
  localparam int unsigned GROUPS = NUM_OUT / LN,
  localparam int unsigned GW     = $clog2(GROUPS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [GW-1:0]             grp,
  input  logic                      dir_q,
  input  logic [LN*CODE_W-1:0]      lanes,
  output logic [NUM_OUT*CODE_W-1:0] bank_o
);
  logic [NUM_OUT*CODE_W-1:0] bank_q, bank_d;

  for (genvar s = 0; s < NUM_OUT; s++) begin : g_slot
    localparam int unsigned FG = s / LN;
    localparam int unsigned FP = s % LN;
    localparam int unsigned RG = (NUM_OUT - 1 - s) / LN;
    localparam int unsigned RP = (NUM_OUT - 1 - s) % LN;
    logic hit;
    always_comb begin
      hit = wr_en && (dir_q ? (grp == GW'(RG)) : (grp == GW'(FG)));
      if (hit) begin
        bank_d[s*CODE_W +: CODE_W] = dir_q ? lanes[RP*CODE_W +: CODE_W]
                                           : lanes[FP*CODE_W +: CODE_W];
      end else begin
        bank_d[s*CODE_W +: CODE_W] = bank_q[s*CODE_W +: CODE_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bank_q <= '0;
    else        bank_q <= bank_d;
  end

  assign bank_o = bank_q;

  a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(bank_q));
endmodule

// File: rtl/coldrv_bank2.sv
module coldrv_bank2 #(
  parameter int unsigned NUM_OUT = 384,
  parameter int unsigned CODE_W  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      line_ld,
  input  logic                      frame_alt,
  input  logic [NUM_OUT*CODE_W-1:0] bank1_i,
  output logic [NUM_OUT*CODE_W-1:0] codes_o,
  output logic [NUM_OUT-1:0]        pol_o
);
  logic [NUM_OUT*CODE_W-1:0] codes_q, codes_d;
  logic                      frame_q, frame_d;

  always_comb begin
    codes_d = codes_q;
    frame_d = frame_q;
    if (line_ld) begin
      codes_d = bank1_i;
      frame_d = frame_alt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      codes_q <= '0;
      frame_q <= 1'b0;
    end else begin
      codes_q <= codes_d;
      frame_q <= frame_d;
    end
  end

  for (genvar s = 0; s < NUM_OUT; s++) begin : g_pol
    assign pol_o[s] = frame_q ^ 1'(s % 2);
  end

  assign codes_o = codes_q;

  a_r8_copy: assert property (@(posedge clk) disable iff (!rst_n)
    line_ld |=> (codes_q == $past(bank1_i)));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !line_ld |=> ($stable(codes_q) && $stable(frame_q)));
endmodule

// File: rtl/coldrv_capture.sv
module coldrv_capture
  import coldrv_pkg::*;
#(
  parameter int unsigned NUM_OUT = 384,
  parameter int unsigned CODE_W  = 8,
  localparam int unsigned PORT_W = CH_PER_PORT * CODE_W,
  localparam int unsigned GW     = $clog2(NUM_OUT / LANES)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      dir_rev,
  input  logic                      start_lo_i,
  input  logic                      start_hi_i,
  output logic                      start_lo_o,
  output logic                      start_hi_o,
  output logic                      start_lo_oe,
  output logic                      start_hi_oe,
  input  logic [PORT_W-1:0]         port_a,
  input  logic [PORT_W-1:0]         port_b,
  input  logic                      inv_a,
  input  logic                      inv_b,
  input  logic                      line_ld,
  input  logic                      frame_alt,
  output logic [NUM_OUT*CODE_W-1:0] gray_codes,
  output logic [NUM_OUT-1:0]        dot_pol
);
  logic [NUM_PORTS-1:0][PORT_W-1:0] raw_in, inv_out;
  logic [NUM_PORTS-1:0]             inv_sel;
  logic [LANES*CODE_W-1:0]          lanes;
  logic [NUM_OUT*CODE_W-1:0]        bank1;
  logic                             wr_en, dir_q;
  logic [GW-1:0]                    grp;

  assign raw_in[0]  = port_a;
  assign raw_in[1]  = port_b;
  assign inv_sel[0] = inv_a;
  assign inv_sel[1] = inv_b;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    coldrv_invert #(.CODE_W(CODE_W), .CH(CH_PER_PORT)) i_inv (
      .data_i (raw_in[p]),
      .inv_i  (inv_sel[p]),
      .data_o (inv_out[p])
    );
    for (genvar c = 0; c < CH_PER_PORT; c++) begin : g_ch
      assign lanes[(p*CH_PER_PORT + c)*CODE_W +: CODE_W] =
        inv_out[p][(CH_PER_PORT-1-c)*CODE_W +: CODE_W];
    end
  end

  coldrv_addr #(.NUM_OUT(NUM_OUT), .LN(LANES)) i_addr (
    .clk        (clk),
    .rst_n      (rst_n),
    .dir_rev    (dir_rev),
    .start_lo_i (start_lo_i),
    .start_hi_i (start_hi_i),
    .wr_en      (wr_en),
    .grp        (grp),
    .dir_q      (dir_q),
    .casc_lo_o  (start_lo_o),
    .casc_hi_o  (start_hi_o)
  );

  coldrv_bank1 #(.NUM_OUT(NUM_OUT), .CODE_W(CODE_W), .LN(LANES)) i_bank1 (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .grp    (grp),
    .dir_q  (dir_q),
    .lanes  (lanes),
    .bank_o (bank1)
  );

  coldrv_bank2 #(.NUM_OUT(NUM_OUT), .CODE_W(CODE_W)) i_bank2 (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_ld   (line_ld),
    .frame_alt (frame_alt),
    .bank1_i   (bank1),
    .codes_o   (gray_codes),
    .pol_o     (dot_pol)
  );

  assign start_lo_oe = dir_rev;
  assign start_hi_oe = !dir_rev;

  a_r6_far_pin_only: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_lo_o, start_hi_o}));
endmodule

// File: tb/test_coldrv_capture.sv
`timescale 1ns/1ps
module test_coldrv_capture;
  localparam int N = 384;
  localparam int W = 8;
  localparam int G = 64;

  logic clk = 1'b0;
  logic rst_n, dir_rev, start_lo_i, start_hi_i;
  logic start_lo_o, start_hi_o, start_lo_oe, start_hi_oe;
  logic [23:0] port_a, port_b;
  logic inv_a, inv_b, line_ld, frame_alt;
  logic [N*W-1:0] gray_codes;
  logic [N-1:0] dot_pol;

  always #2 clk = ~clk;

  coldrv_capture i_coldrv_capture (
    .clk(clk), .rst_n(rst_n), .dir_rev(dir_rev),
    .start_lo_i(start_lo_i), .start_hi_i(start_hi_i),
    .start_lo_o(start_lo_o), .start_hi_o(start_hi_o),
    .start_lo_oe(start_lo_oe), .start_hi_oe(start_hi_oe),
    .port_a(port_a), .port_b(port_b), .inv_a(inv_a), .inv_b(inv_b),
    .line_ld(line_ld), .frame_alt(frame_alt),
    .gray_codes(gray_codes), .dot_pol(dot_pol)
  );

  typedef struct {
    int         slot;
    logic [7:0] code;
    logic       pol;
    string      req;
  } exp_t;

  exp_t q[$];
  exp_t mon_e;
  logic [7:0] m1[N];
  logic [7:0] m2[N];
  logic       mframe;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic check(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Monitor: pops expected slot contents and compares at the falling edge.
  always @(negedge clk) begin
    while (q.size() > 0) begin
      mon_e = q.pop_front();
      checks++;
      if (gray_codes[mon_e.slot*W +: W] !== mon_e.code || dot_pol[mon_e.slot] !== mon_e.pol) begin
        errors++;
        $display("FAIL %s slot %0d actual=%0h/%0b expected=%0h/%0b", mon_e.req, mon_e.slot,
                 gray_codes[mon_e.slot*W +: W], dot_pol[mon_e.slot], mon_e.code, mon_e.pol);
      end
    end
  end

  function automatic logic [7:0] code_for(int line, int g, int k);
    return 8'((line * 37 + g * 11 + k * 59 + 5) ^ (g << 3));
  endfunction

  task automatic push_all(string req);
    for (int i = 0; i < N; i++) q.push_back('{i, m2[i], mframe ^ i[0], req});
  endtask

  task automatic load_now(logic fr, string req);
    @(negedge clk);
    line_ld = 1'b1; frame_alt = fr;
    for (int i = 0; i < N; i++) m2[i] = m1[i];
    mframe = fr;
    @(posedge clk); #1;
    push_all(req);
    @(negedge clk);
    line_ld = 1'b0;
  endtask

  task automatic send_line(bit dir, int line, bit ia, bit ib, int ld_grp, bit extra_start);
    @(negedge clk);
    dir_rev = dir;
    if (dir) start_hi_i = 1'b1; else start_lo_i = 1'b1;
    for (int g = 0; g < G; g++) begin
      @(negedge clk);
      line_ld = 1'b0;
      start_lo_i = 1'b0; start_hi_i = 1'b0;
      if (extra_start && g == 10) begin  // R11: restart attempt mid-line
        if (dir) start_hi_i = 1'b1; else start_lo_i = 1'b1;
      end
      inv_a = ia; inv_b = ib;
      port_a = {code_for(line, g, 0), code_for(line, g, 1), code_for(line, g, 2)};
      port_b = {code_for(line, g, 3), code_for(line, g, 4), code_for(line, g, 5)};
      // R6: far-side pulse only during group 63
      check("R6", "far pulse", dir ? start_lo_o : start_hi_o, (g == G - 1));
      if (g == 0 || g == G - 1) check("R6", "near pulse", dir ? start_hi_o : start_lo_o, 0);
      if (g == ld_grp) begin
        line_ld = 1'b1; frame_alt = line[0];
        for (int i = 0; i < N; i++) m2[i] = m1[i];
        mframe = line[0];
      end
      for (int k = 0; k < 6; k++) begin
        int slot;
        slot = dir ? (N - 1 - (6 * g + k)) : (6 * g + k);
        m1[slot] = code_for(line, g, k) ^ {8{(k < 3) ? ia : ib}};
      end
      if (g == ld_grp) begin
        @(posedge clk); #1;
        push_all("R9");
      end
    end
    @(negedge clk);
    line_ld = 1'b0; start_lo_i = 1'b0; start_hi_i = 1'b0;
    check("R7", "pulse after end", start_lo_o | start_hi_o, 0);
  endtask

  task automatic idle_junk(int n, bit wrong_pin);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      port_a = 24'(c * 24'h135791 + 7); port_b = 24'(c * 24'h2468AC + 3);
      start_hi_i = wrong_pin && (c == 0) && !dir_rev;
      start_lo_i = wrong_pin && (c == 0) && dir_rev;
    end
    @(negedge clk);
    start_lo_i = 1'b0; start_hi_i = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; dir_rev = 1'b0; start_lo_i = 1'b0; start_hi_i = 1'b0;
    port_a = '0; port_b = '0; inv_a = 1'b0; inv_b = 1'b0;
    line_ld = 1'b0; frame_alt = 1'b0;
    for (int i = 0; i < N; i++) begin m1[i] = '0; m2[i] = '0; end
    mframe = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", "codes in reset", gray_codes == '0, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "codes zero", gray_codes == '0, 1);
    check("R1", "polarity pattern", dot_pol[3:0], 4'b1010);
    check("R1", "start outputs", {start_lo_o, start_hi_o}, 2'b00);
    check("R6", "oe forward", {start_lo_oe, start_hi_oe}, 2'b01);
    dir_rev = 1'b1; #1;
    check("R6", "oe reverse", {start_lo_oe, start_hi_oe}, 2'b10);
    dir_rev = 1'b0;

    send_line(0, 1, 0, 0, -1, 0);          // R2 forward order
    load_now(0, "R2");
    send_line(1, 2, 1, 0, -1, 0);          // R3 reverse, R4 port A inverted
    load_now(1, "R3 R4 R10");
    send_line(0, 3, 0, 1, -1, 1);          // R11 restart ignored, R4 port B
    load_now(0, "R11 R4 R10");
    idle_junk(6, 1);                       // R5 wrong pin, R7 idle
    load_now(1, "R7 R5");
    send_line(1, 4, 1, 1, 20, 0);          // R9 load during capture
    load_now(0, "R8");
    send_line(0, 5, 0, 0, -1, 0);
    @(posedge clk); #1;
    push_all("R8 hold");                   // bank2 unchanged without strobe
    repeat (3) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule